// File: doc/BRIEF.md
# Three-Level Bus Master Arbiter

This block decides which of three masters drives a single shared system bus: a real-time DMA engine, the CPU, and masters on an expansion bus. The CPU is the default owner. To take the bus away from it, the arbiter runs the CPU's bus-request / bus-grant / bus-grant-acknowledge handshake. It raises a bus request, waits for the CPU to answer with a grant, and then asserts the acknowledge. That acknowledge holds the CPU off the bus while the arbiter hands it to DMA or to an expansion master. Grants begin and end only on a slot-boundary strobe, which marks the fixed DMA slot schedule.

DMA always wins. If DMA and an expansion master request together, DMA is granted. A strobe that finds DMA requesting while an expansion master owns the bus moves the grant straight to DMA. The acknowledge stays asserted through that move, so the CPU never slips in between.

An expansion master is limited to `LINE_CYCLES` clocks of ownership (one scanline). When it reaches the limit, the arbiter takes the bus back without waiting for a strobe and pulses a timeout flag. It also refuses that master until the master drops its request. Data transfer on the bus is handled elsewhere.

The CPU handshake pins are active-high by default. The parameter `CPU_ACTIVE_LOW` inverts all three pins for a CPU with active-low handshake lines. The requirements below describe the default polarity.

Top module: `bus_master_arbiter`

## Requirements
- R1: During and right after reset, `cpu_br`, `cpu_bgack`, `dma_grant`, `exp_grant` and `exp_timeout` are all 0, and the CPU owns the bus.
- R2: While the CPU owns the bus, `cpu_br` rises only in the cycle after a clock edge that sampled `slot_strobe`=1 together with `dma_req`=1 or an eligible `exp_req`=1. Requests without a strobe leave `cpu_br` at 0.
- R3: No acknowledge and no grant is issued before `cpu_bg` is seen. One clock after `cpu_bg`=1 is sampled while the request is pending, `cpu_bgack` becomes 1 and `cpu_br` returns to 0. `cpu_bg` has no effect in any other state.
- R4: After the acknowledge, a grant is issued only on an edge that samples `slot_strobe`=1. DMA is chosen over expansion. If neither master is requesting at that strobe, the bus goes back to the CPU.
- R5: A DMA grant ends only on a strobe edge that samples `dma_req`=0. At that point `dma_grant` and `cpu_bgack` both fall and the CPU resumes.
- R6: While `dma_req` stays 1, `dma_grant` stays 1 across any number of strobes.
- R7: When only an expansion master requests, it is granted after the handshake. Its grant ends on a strobe edge that samples `exp_req`=0.
- R8: A strobe edge that samples `dma_req`=1 while `exp_grant`=1 moves the grant to DMA in the next cycle. `cpu_bgack` stays 1 throughout.
- R9: `exp_grant` is never 1 for more than `LINE_CYCLES` consecutive cycles. On the cycle it is forced low, `exp_timeout` is 1 for exactly one cycle.
- R10: After a timeout, the expansion request is ignored (no `cpu_br`, no grant) until `exp_req` has been sampled at 0 at least once.
- R11: `dma_grant` and `exp_grant` are never both 1. Whenever either one is 1, `cpu_bgack` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_strobe | input | 1 | One-cycle pulse at each DMA slot boundary |
| dma_req | input | 1 | DMA engine wants the bus |
| exp_req | input | 1 | Expansion master wants the bus |
| cpu_bg | input | 1 | Bus grant returned by the CPU |
| cpu_br | output | 1 | Bus request to the CPU |
| cpu_bgack | output | 1 | Bus grant acknowledge; holds the CPU off the bus |
| dma_grant | output | 1 | DMA engine owns the bus |
| exp_grant | output | 1 | Expansion master owns the bus |
| exp_timeout | output | 1 | One-cycle pulse when an expansion hold is forced to end |

## Verification
Every output comes straight from a state register. A result therefore appears in the first cycle after the clock edge that sampled its cause: `cpu_br` one edge after the strobe, `cpu_bgack` one edge after `cpu_bg`, and a grant one edge after the deciding strobe. The forced release and its timeout pulse both appear `LINE_CYCLES` edges after the expansion grant first shows. The bench drives inputs on the falling edge. A reference model, computed from the requirements, advances on each rising edge using the inputs the DUT sampled there. The bench compares the outputs on the next falling edge, which is exactly one edge later. The directed corner cases count the same edges before they check.

// File: rtl/bma_pkg.sv
package bma_pkg;
   typedef enum logic [2:0] {
      OWN_CPU  = 3'd0,
      OWN_REQ  = 3'd1,
      OWN_ACK  = 3'd2,
      OWN_DMA  = 3'd3,
      OWN_EXP  = 3'd4
   } own_state_t;
endpackage

// File: rtl/bma_cpu_pins.sv
module bma_cpu_pins #(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic br_h,
   input  logic bgack_h,
   input  logic bg_pin,
   output logic br_pin,
   output logic bgack_pin,
   output logic bg_h
);
   generate
      if (ACTIVE_LOW) begin : g_low
         assign br_pin    = ~br_h;
         assign bgack_pin = ~bgack_h;
         assign bg_h      = ~bg_pin;
      end else begin : g_high
         assign br_pin    = br_h;
         assign bgack_pin = bgack_h;
         assign bg_h      = bg_pin;
      end
   endgenerate
endmodule

// File: rtl/bma_hold_timer.sv
module bma_hold_timer #(
   parameter int LINE_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CNT_W = $clog2(LINE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   initial begin
      if (LINE_CYCLES < 2) $error("LINE_CYCLES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (run) cnt_q <= cnt_q + 1'b1;
      else          cnt_q <= '0;
   end

   assign expire = run && (cnt_q == LAST);
endmodule

// File: rtl/bma_owner_fsm.sv
module bma_owner_fsm
   import bma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slot,
   input  logic       dma_req,
   input  logic       exp_req,
   input  logic       exp_ok,
   input  logic       bg,
   input  logic       expire,
   output own_state_t state
);
   own_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         OWN_CPU: if (slot && (dma_req || exp_ok)) nxt = OWN_REQ;
         OWN_REQ: if (bg) nxt = OWN_ACK;
         OWN_ACK: if (slot) begin
            if (dma_req)     nxt = OWN_DMA;
            else if (exp_ok) nxt = OWN_EXP;
            else             nxt = OWN_CPU;
         end
         OWN_DMA: if (slot && !dma_req) nxt = OWN_CPU;
         OWN_EXP: begin
            if (slot && dma_req)      nxt = OWN_DMA;
            else if (expire)          nxt = OWN_CPU;
            else if (slot && !exp_req) nxt = OWN_CPU;
         end
         default: nxt = OWN_CPU;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= OWN_CPU;
      else        state <= nxt;
   end
endmodule

// File: rtl/bus_master_arbiter.sv
module bus_master_arbiter
   import bma_pkg::*;
#(
   parameter int LINE_CYCLES    = 1024,
   parameter bit CPU_ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slot_strobe,
   input  logic dma_req,
   input  logic exp_req,
   input  logic cpu_bg,
   output logic cpu_br,
   output logic cpu_bgack,
   output logic dma_grant,
   output logic exp_grant,
   output logic exp_timeout
);
   own_state_t state;
   logic br_h, bgack_h, bg_h;
   logic expire, lock_q, exp_ok, tmo_q;

   assign exp_ok = exp_req && !lock_q;

   bma_owner_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .slot    (slot_strobe),
      .dma_req (dma_req),
      .exp_req (exp_req),
      .exp_ok  (exp_ok),
      .bg      (bg_h),
      .expire  (expire),
      .state   (state)
   );

   bma_hold_timer #(.LINE_CYCLES(LINE_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (state == OWN_EXP),
      .expire (expire)
   );

   bma_cpu_pins #(.ACTIVE_LOW(CPU_ACTIVE_LOW)) u_pins (
      .br_h      (br_h),
      .bgack_h   (bgack_h),
      .bg_pin    (cpu_bg),
      .br_pin    (cpu_br),
      .bgack_pin (cpu_bgack),
      .bg_h      (bg_h)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         tmo_q  <= 1'b0;
      end else begin
         tmo_q <= expire;
         if (expire)       lock_q <= 1'b1;
         else if (!exp_req) lock_q <= 1'b0;
      end
   end

   assign br_h        = (state == OWN_REQ);
   assign bgack_h     = (state == OWN_ACK) || (state == OWN_DMA) || (state == OWN_EXP);
   assign dma_grant   = (state == OWN_DMA);
   assign exp_grant   = (state == OWN_EXP);
   assign exp_timeout = tmo_q;
endmodule

// File: rtl/bma_checker.sv
module bma_checker #(
   parameter int LINE_CYCLES = 1024
) (
   input logic clk,
   input logic rst_n,
   input logic slot_strobe,
   input logic dma_req,
   input logic exp_req,
   input logic bg_h,
   input logic br_h,
   input logic bgack_h,
   input logic dma_grant,
   input logic exp_grant,
   input logic exp_timeout
);
   localparam int HW = $clog2(LINE_CYCLES + 2);
   logic [HW-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held_q <= '0;
      else if (exp_grant) held_q <= held_q + 1'b1;
      else                held_q <= '0;
   end

   a_r2_br_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(br_h) |-> $past(slot_strobe));
   a_r3_ack_after_bg: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bgack_h) |-> $past(bg_h) && $past(br_h));
   a_r4_dma_grant_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_grant) |-> $past(slot_strobe) && $past(dma_req));
   a_r5_dma_release_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_grant) |-> $past(slot_strobe) && !$past(dma_req));
   a_r8_dma_preempts: assert property (@(posedge clk) disable iff (!rst_n)
      exp_grant && slot_strobe && dma_req |=> dma_grant && bgack_h);
   a_r9_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(held_q) <= LINE_CYCLES);
   a_r9_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
      exp_timeout |=> !exp_timeout);
   a_r11_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({dma_grant, exp_grant}) <= 1);
   a_r11_grant_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_grant || exp_grant) |-> bgack_h);
endmodule

bind bus_master_arbiter bma_checker #(.LINE_CYCLES(LINE_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .slot_strobe (slot_strobe),
   .dma_req     (dma_req),
   .exp_req     (exp_req),
   .bg_h        (bg_h),
   .br_h        (br_h),
   .bgack_h     (bgack_h),
   .dma_grant   (dma_grant),
   .exp_grant   (exp_grant),
   .exp_timeout (exp_timeout)
);

// File: tb/bus_master_arbiter_tb_top.sv
module bus_master_arbiter_tb_top;
   localparam int L = 40;
   localparam int M_CPU = 0, M_REQ = 1, M_ACK = 2, M_DMA = 3, M_EXP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slot_strobe = 1'b0, dma_req = 1'b0, exp_req = 1'b0, cpu_bg = 1'b0;
   logic cpu_br, cpu_bgack, dma_grant, exp_grant, exp_timeout;

   int checks = 0;
   int fails  = 0;

   int m_st = M_CPU;
   int m_cnt = 0;
   bit m_lock = 1'b0;
   bit m_tmo = 1'b0;

   always #4 clk = ~clk;

   bus_master_arbiter #(.LINE_CYCLES(L)) dut_i (
      .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe), .dma_req(dma_req),
      .exp_req(exp_req), .cpu_bg(cpu_bg), .cpu_br(cpu_br), .cpu_bgack(cpu_bgack),
      .dma_grant(dma_grant), .exp_grant(exp_grant), .exp_timeout(exp_timeout)
   );

   task automatic check(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int next_state(int st, bit s, bit d, bit e, bit ok, bit g, bit ex);
      case (st)
         M_CPU: return (s && (d || ok)) ? M_REQ : M_CPU;
         M_REQ: return g ? M_ACK : M_REQ;
         M_ACK: return !s ? M_ACK : (d ? M_DMA : (ok ? M_EXP : M_CPU));
         M_DMA: return (s && !d) ? M_CPU : M_DMA;
         default: begin
            if (s && d) return M_DMA;
            if (ex) return M_CPU;
            if (s && !e) return M_CPU;
            return M_EXP;
         end
      endcase
   endfunction

   task automatic model_edge();
      bit ex;
      bit ok;
      ex = (m_st == M_EXP) && (m_cnt == L - 1);
      ok = exp_req && !m_lock;
      m_tmo = ex;
      m_cnt = (m_st == M_EXP) ? m_cnt + 1 : 0;
      if (ex) m_lock = 1'b1;
      else if (!exp_req) m_lock = 1'b0;
      m_st = next_state(m_st, slot_strobe, dma_req, exp_req, ok, cpu_bg, ex);
   endtask

   task automatic compare_model();
      check("R2 br vs model", cpu_br, m_st == M_REQ);
      check("R11 bgack vs model", cpu_bgack, m_st >= M_ACK);
      check("R4 dma_grant vs model", dma_grant, m_st == M_DMA);
      check("R7 exp_grant vs model", exp_grant, m_st == M_EXP);
      check("R9 timeout vs model", exp_timeout, m_tmo);
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_model();
   endtask

   task automatic drive(bit s, bit d, bit e, bit g);
      slot_strobe = s; dma_req = d; exp_req = e; cpu_bg = g;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 br in reset", cpu_br, 1'b0);
      check("R1 bgack in reset", cpu_bgack, 1'b0);
      rst_n = 1'b1;
      step();
      check("R1 dma_grant after reset", dma_grant, 1'b0);
      check("R1 exp_grant after reset", exp_grant, 1'b0);
      check("R1 timeout after reset", exp_timeout, 1'b0);

      // DMA handshake
      drive(0, 1, 0, 0); step(); step();
      check("R2 no br without strobe", cpu_br, 1'b0);
      drive(1, 1, 0, 0); step();
      check("R2 br after strobe", cpu_br, 1'b1);
      drive(1, 1, 0, 0); step(); step();
      check("R3 no ack before bg", cpu_bgack, 1'b0);
      check("R3 no grant before bg", dma_grant, 1'b0);
      drive(0, 1, 0, 1); step();
      check("R3 ack after bg", cpu_bgack, 1'b1);
      check("R3 br drops", cpu_br, 1'b0);
      check("R3 no grant yet", dma_grant, 1'b0);
      drive(0, 1, 0, 0); step();
      check("R4 grant waits for strobe", dma_grant, 1'b0);
      drive(1, 1, 0, 0); step();
      check("R4 dma granted on strobe", dma_grant, 1'b1);
      step(); step();
      check("R6 dma held across strobes", dma_grant, 1'b1);
      drive(0, 0, 0, 1); step();
      check("R6 release waits for strobe", dma_grant, 1'b1);
      drive(1, 0, 0, 0); step();
      check("R5 dma released", dma_grant, 1'b0);
      check("R5 bgack released", cpu_bgack, 1'b0);

      // Expansion grant, then DMA preemption
      drive(1, 0, 1, 0); step();
      drive(0, 0, 1, 1); step();
      drive(1, 0, 1, 0); step();
      check("R7 exp granted", exp_grant, 1'b1);
      drive(1, 1, 1, 0); step();
      check("R8 dma preempts", dma_grant, 1'b1);
      check("R8 exp dropped", exp_grant, 1'b0);
      check("R8 bgack kept", cpu_bgack, 1'b1);
      drive(1, 0, 1, 0); step();

      // Timeout
      drive(1, 0, 1, 0); step();
      drive(0, 0, 1, 1); step();
      drive(1, 0, 1, 0); step();
      check("R7 exp granted again", exp_grant, 1'b1);
      drive(0, 0, 1, 0);
      for (int i = 0; i < L - 1; i++) step();
      check("R9 still held at limit", exp_grant, 1'b1);
      step();
      check("R9 forced release", exp_grant, 1'b0);
      check("R9 timeout pulse", exp_timeout, 1'b1);
      step();
      check("R9 timeout one cycle", exp_timeout, 1'b0);
      drive(1, 0, 1, 0); step(); step();
      check("R10 locked out", cpu_br, 1'b0);
      drive(0, 0, 0, 0); step();
      drive(1, 0, 1, 0); step();
      check("R10 lock cleared", cpu_br, 1'b1);
      drive(0, 1, 1, 1); step();
      drive(1, 1, 1, 0); step();
      check("R4 dma wins over exp", dma_grant, 1'b1);
      check("R11 single grant", exp_grant, 1'b0);
      drive(1, 0, 0, 0); step();
      check("R7 exp release on strobe", exp_grant, 1'b0);

      // Constrained random
      for (int n = 0; n < 4000; n++) begin
         bit d, e;
         d = dma_req; e = exp_req;
         if ($urandom_range(7) == 0) d = !d;
         if ($urandom_range(15) == 0) e = !e;
         drive($urandom_range(2) == 0, d, e, $urandom_range(1) == 0);
         step();
         check("R11 grant exclusive", dma_grant && exp_grant, 1'b0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule